// File: doc/BRIEF.md
# Full-Cycle Serial Host Shift Engine

This block is a serial host controller. It produces a serial clock, an active-low select and a data output from the system clock, and it shifts in the data returned by an attached peripheral. The peripheral is assumed to change its output after each falling clock edge and to sample its input on each rising edge. A parallel command side starts a transfer of one or more bytes. Each byte the engine takes is acknowledged with a strobe, and each byte it receives is presented with a valid strobe.

Two capture modes are available. In standard mode the engine behaves like a mode 0 host. It changes its data output after falling edges and samples the input on the next rising edge, which leaves the peripheral only half a clock period. In full-cycle mode the output changes on rising edges. The input is sampled on the falling edge one whole period after the edge that launched it, so the peripheral's clock-to-output delay can use nearly the whole period. The serial clock rate comes from a half-period count in system clocks. The mode and the rate are captured when a transfer is started.

Top module: `spi_fullcycle_host`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and `busy`, `done`, `rx_valid` and `tx_taken` are all 0.
- R2: `sck` is low whenever `cs_n` is high. While clocking, each level of `sck` lasts H system clocks, so the period is 2H. H is `div_half`, and a value of 0 is treated as 1.
- R3: The first rising edge of `sck` comes H system clocks after `cs_n` falls. `cs_n` rises H system clocks after the last falling edge. `done` is high for exactly one cycle, which is the first cycle in which `cs_n` reads high again.
- R4: A transfer of N bytes gives exactly 8N rising and 8N falling `sck` edges. Clocking continues without a pause across byte boundaries.
- R5: Standard mode (`cap_mode`=0) works as follows. The MSB of each byte is on `mosi` when `cs_n` falls or when the previous byte ends. The data bits go out MSB first and change right after falling edges. `miso` is sampled at rising edges. If the peripheral's output delay exceeds H system clocks, the received data is wrong.
- R6: Full-cycle mode (`cap_mode`=1) works as follows. `mosi` changes at rising edges. `miso` is sampled at the falling edge one period after the edge that launched it. The falling edge that ends the last bit is always issued before `cs_n` rises. Data is received correctly for output delays up to nearly 2H system clocks.
- R7: After the eighth bit of each byte is sampled, `rx_valid` is high for one cycle and `rx_data` holds that byte, MSB first.
- R8: `tx_taken` pulses for one cycle right after a byte is taken from `tx_data`. This includes the first byte at start. The next byte must be on `tx_data` before the next byte is taken.
- R9: `cap_mode` and `div_half` are sampled only when a transfer starts. Changing them during a transfer has no effect on it.
- R10: `start` is ignored while `busy` is high. A `start` with `byte_count` of 0 is also ignored: `cs_n` stays high and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| cap_mode | input | 1 | 0 selects standard capture, 1 selects full-cycle capture |
| div_half | input | DIV_W | Serial clock half period in system clocks (0 means 1) |
| byte_count | input | CNT_W | Number of bytes to transfer |
| tx_data | input | 8 | Next byte to send |
| tx_taken | output | 1 | One-cycle pulse after a byte is taken from tx_data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low peripheral select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions rely on a few conditions at the inputs. The reset is applied before the first edge. `tx_data` is refreshed between two `tx_taken` strobes. `miso` is settled at the system clock edge on which the capture occurs. The bench meets these conditions as follows. It drives all command inputs on the falling system edge. It updates `tx_data` as soon as it sees `tx_taken`. Its peripheral model changes `miso` after delays chosen so that they never coincide with a system clock edge. Some of those delays are deliberately beyond half a period, to show where standard capture breaks down.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_FIN  = 2'd3
  } xfer_state_t;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FULL = 1'b1
  } cap_mode_t;

  // Edge on which the host moves its output to the next bit.
  function automatic logic launch_edge(input cap_mode_t m, input logic rise, input logic fall);
    return (m == MODE_FULL) ? rise : fall;
  endfunction

  // Edge on which the host samples the returned bit.
  function automatic logic capture_edge(input cap_mode_t m, input logic rise, input logic fall);
    return (m == MODE_FULL) ? fall : rise;
  endfunction

endpackage

// File: rtl/spi_fc_sckgen.sv
module spi_fc_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             toggle,
  input  logic [DIV_W-1:0] half_q,
  output logic             sck,
  output logic             tick,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;

  assign tick     = run && (cnt_q == (half_q - DIV_W'(1)));
  assign rise_evt = tick && toggle && !sck_q;
  assign fall_evt = tick && toggle && sck_q;
  assign sck      = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      if (toggle) sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R2
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (sck_q != $past(sck_q))) |-> $past(rise_evt || fall_evt));

endmodule

// File: rtl/spi_fc_txshift.sv
module spi_fc_txshift
  import spi_fc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_first,
  input  logic                 shift,
  input  logic                 more,
  input  logic [BYTE_BITS-1:0] tx_data,
  output logic                 mosi,
  output logic                 tx_taken
);

  localparam int BIT_CW = $clog2(BYTE_BITS);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_BITS - 1);

  logic [BYTE_BITS-1:0] sh_q;
  logic [BIT_CW-1:0]    n_q;
  logic                 taken_q;
  logic                 byte_wrap;
  logic                 take;

  assign byte_wrap = shift && (n_q == LAST_BIT);
  assign take      = load_first || (byte_wrap && more);
  assign mosi      = sh_q[BYTE_BITS-1];
  assign tx_taken  = taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      n_q     <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (load_first) begin
        sh_q <= tx_data;
        n_q  <= '0;
      end else if (shift) begin
        if (byte_wrap) begin
          sh_q <= more ? tx_data : '0;
          n_q  <= '0;
        end else begin
          sh_q <= {sh_q[BYTE_BITS-2:0], 1'b0};
          n_q  <= n_q + BIT_CW'(1);
        end
      end
    end
  end

  // R8
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> !tx_taken);

endmodule

// File: rtl/spi_fc_rxshift.sv
module spi_fc_rxshift
  import spi_fc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  logic                 miso,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 rx_valid
);

  localparam int BIT_CW = $clog2(BYTE_BITS);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_BITS - 1);

  logic [BYTE_BITS-1:0] sh_q;
  logic [BYTE_BITS-1:0] out_q;
  logic [BIT_CW-1:0]    n_q;
  logic                 vld_q;
  logic [BYTE_BITS-1:0] next_sh;

  assign next_sh  = {sh_q[BYTE_BITS-2:0], miso};
  assign rx_data  = out_q;
  assign rx_valid = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
      n_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clear) begin
        n_q <= '0;
      end else if (capture) begin
        sh_q <= next_sh;
        if (n_q == LAST_BIT) begin
          out_q <= next_sh;
          vld_q <= 1'b1;
          n_q   <= '0;
        end else begin
          n_q <= n_q + BIT_CW'(1);
        end
      end
    end
  end

  // R7
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/spi_fullcycle_host.sv
module spi_fullcycle_host
  import spi_fc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 cap_mode,
  input  logic [DIV_W-1:0]     div_half,
  input  logic [CNT_W-1:0]     byte_count,
  input  logic [BYTE_BITS-1:0] tx_data,
  output logic                 tx_taken,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 busy,
  output logic                 done,
  output logic                 sck,
  output logic                 cs_n,
  output logic                 mosi,
  input  logic                 miso
);

  localparam int BIT_CW = $clog2(BYTE_BITS);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_BITS - 1);

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  xfer_state_t       state_q;
  cap_mode_t         mode_q;
  logic [DIV_W-1:0]  half_q;
  logic [CNT_W-1:0]  left_q;
  logic [BIT_CW-1:0] fbit_q;
  logic              cs_n_q;

  // Named internal events
  logic go;
  logic run;
  logic toggle;
  logic tick;
  logic rise_evt;
  logic fall_evt;
  logic launch_evt;
  logic capture_evt;
  logic more_bytes;

  assign go          = (state_q == ST_IDLE) && start && (byte_count != '0);
  assign run         = (state_q == ST_RUN) || (state_q == ST_HOLD);
  assign toggle      = (state_q == ST_RUN);
  assign launch_evt  = launch_edge(mode_q, rise_evt, fall_evt);
  assign capture_evt = capture_edge(mode_q, rise_evt, fall_evt);
  assign more_bytes  = (left_q > CNT_W'(1));

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);
  assign cs_n = cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_STD;
      half_q  <= DIV_W'(1);
      left_q  <= '0;
      fbit_q  <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_RUN;
            mode_q  <= cap_mode_t'(cap_mode);
            half_q  <= eff_half(div_half);
            left_q  <= byte_count;
            fbit_q  <= '0;
            cs_n_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (fall_evt) begin
            if (fbit_q == LAST_BIT) begin
              fbit_q <= '0;
              if (left_q == CNT_W'(1)) state_q <= ST_HOLD;
              else                     left_q  <= left_q - CNT_W'(1);
            end else begin
              fbit_q <= fbit_q + BIT_CW'(1);
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_fc_sckgen #(.DIV_W(DIV_W)) i_sckgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .toggle   (toggle),
    .half_q   (half_q),
    .sck      (sck),
    .tick     (tick),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  spi_fc_txshift i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (go),
    .shift      (launch_evt),
    .more       (more_bytes),
    .tx_data    (tx_data),
    .mosi       (mosi),
    .tx_taken   (tx_taken)
  );

  spi_fc_rxshift i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .capture  (capture_evt),
    .miso     (miso),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R3
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_with_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sck));

  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(half_q)));

endmodule

// File: tb/test_spi_fullcycle_host.sv
`timescale 1ns/1ps
module test_spi_fullcycle_host;

  localparam int DIV_W = 4;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic       mode;
    logic [3:0] div;
    logic [3:0] nb;
    logic [7:0] dly;
    logic       ok;
  } vec_t;

  // mode, div_half, bytes, peripheral delay (ns), capture expected correct
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd4, 4'd2, 8'd3,  1'b1},
    '{1'b0, 4'd4, 4'd1, 8'd13, 1'b1},
    '{1'b0, 4'd4, 4'd2, 8'd22, 1'b0},
    '{1'b1, 4'd4, 4'd2, 8'd3,  1'b1},
    '{1'b1, 4'd4, 4'd3, 8'd22, 1'b1},
    '{1'b1, 4'd4, 4'd2, 8'd37, 1'b1},
    '{1'b1, 4'd2, 4'd1, 8'd17, 1'b1},
    '{1'b0, 4'd2, 4'd1, 8'd13, 1'b0},
    '{1'b1, 4'd0, 4'd1, 8'd7,  1'b1},
    '{1'b0, 4'd1, 4'd2, 8'd3,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cap_mode = 1'b0;
  logic [DIV_W-1:0] div_half = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] tx_data = '0;
  logic tx_taken, rx_valid, busy, done, sck, cs_n, mosi;
  logic [7:0] rx_data;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_fullcycle_host #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_spi_fullcycle_host (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_mode(cap_mode),
    .div_half(div_half), .byte_count(byte_count), .tx_data(tx_data),
    .tx_taken(tx_taken), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .done(done), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor state
  int cyc = 0, hexp = 1;
  int rises, falls, first_rise, last_rise_c, last_fall, cs_fall_c, cs_rise_c;
  int period_bad, duty_bad, done_cnt, done_c, mbit, rxn, tidx;
  logic sck_p = 1'b0, cs_p = 1'b1, mosi_prev = 1'b0;
  logic [7:0] mosi_got [8];
  logic [7:0] rx_got [8];
  logic [7:0] tbytes [8];
  logic [7:0] pbytes [8];

  // Peripheral model
  int dly = 3;
  int pidx = 0;

  function automatic logic pbit(input int i);
    if (i >= 64) return 1'b0;
    return pbytes[i / 8][7 - (i % 8)];
  endfunction

  always @(negedge cs_n) begin
    pidx = 0;
    #(dly);
    miso = pbit(0);
  end

  always @(negedge sck) begin
    if (!cs_n) begin
      pidx++;
      #(dly);
      miso = pbit(pidx);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cs_p && !cs_n) cs_fall_c = cyc;
    if (!cs_p && cs_n) cs_rise_c = cyc;
    if (!sck_p && sck) begin
      if (rises > 0 && (cyc - last_rise_c) != 2 * hexp) period_bad++;
      if (rises > 0 && (cyc - last_fall) != hexp) duty_bad++;
      if (rises == 0) first_rise = cyc;
      last_rise_c = cyc;
      rises++;
      if (mbit < 64) mosi_got[mbit / 8][7 - (mbit % 8)] = mosi_prev;
      mbit++;
    end
    if (sck_p && !sck) begin
      if ((cyc - last_rise_c) != hexp) duty_bad++;
      falls++;
      last_fall = cyc;
    end
    if (done) begin
      done_cnt++;
      done_c = cyc;
    end
    if (rx_valid) begin
      if (rxn < 8) rx_got[rxn] = rx_data;
      rxn++;
    end
    if (tx_taken) begin
      tidx++;
      tx_data = tbytes[tidx % 8];
    end
    sck_p = sck;
    cs_p = cs_n;
    mosi_prev = mosi;
  end

  task automatic run_xfer(input vec_t v, input int vi, input bit poke);
    string mr;
    int bad;
    mr = v.mode ? "R6" : "R5";
    hexp = (v.div == 0) ? 1 : int'(v.div);
    dly = int'(v.dly);
    for (int i = 0; i < 8; i++) begin
      tbytes[i] = 8'hA5 ^ 8'(vi * 16 + i * 37);
      pbytes[i] = 8'(8'h3C + vi * 29 + i * 91);
    end
    rises = 0; falls = 0; period_bad = 0; duty_bad = 0; done_cnt = 0;
    mbit = 0; rxn = 0; tidx = 0; first_rise = 0; last_fall = 0;
    tx_data = tbytes[0];
    @(negedge clk);
    start = 1'b1; cap_mode = v.mode; div_half = v.div; byte_count = v.nb;
    @(negedge clk);
    start = 1'b0;
    // R9: change configuration while the transfer runs
    cap_mode = ~v.mode; div_half = 4'd9;
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; byte_count = 4'd5;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);

    check(rises == 8 * int'(v.nb), "R4", $sformatf("v%0d rising edges", vi), rises, 8 * int'(v.nb));
    check(falls == 8 * int'(v.nb), "R4", $sformatf("v%0d falling edges", vi), falls, 8 * int'(v.nb));
    check(period_bad == 0 && duty_bad == 0, "R2", $sformatf("v%0d period/duty errors", vi),
          period_bad + duty_bad, 0);
    check(first_rise - cs_fall_c == hexp, "R3", $sformatf("v%0d cs to first rise", vi),
          first_rise - cs_fall_c, hexp);
    check(cs_rise_c - last_fall == hexp, "R3", $sformatf("v%0d last fall to cs rise", vi),
          cs_rise_c - last_fall, hexp);
    check(done_cnt == 1 && done_c == cs_rise_c, "R3", $sformatf("v%0d done pulse cycles", vi),
          done_cnt, 1);
    check(rxn == int'(v.nb), "R7", $sformatf("v%0d rx_valid strobes", vi), rxn, int'(v.nb));
    check(tidx == int'(v.nb), "R8", $sformatf("v%0d tx_taken pulses", vi), tidx, int'(v.nb));
    for (int i = 0; i < int'(v.nb); i++)
      check(mosi_got[i] == tbytes[i], mr, $sformatf("v%0d mosi byte %0d", vi, i),
            int'(mosi_got[i]), int'(tbytes[i]));
    bad = 0;
    for (int i = 0; i < int'(v.nb); i++) begin
      if (v.ok)
        check(rx_got[i] == pbytes[i], mr, $sformatf("v%0d rx byte %0d (R9 cfg held)", vi, i),
              int'(rx_got[i]), int'(pbytes[i]));
      else if (rx_got[i] != pbytes[i]) bad++;
    end
    if (!v.ok)
      check(bad > 0, "R5", $sformatf("v%0d late data must break standard capture", vi), bad, 1);
    check(!busy && cs_n && !sck, "R10", $sformatf("v%0d idle after transfer", vi),
          int'({busy, cs_n, sck}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1 && sck == 1'b0, "R1", "cs_n/sck in reset", int'({cs_n, sck}), 2);
    check(!busy && !done && !rx_valid && !tx_taken, "R1", "status in reset",
          int'({busy, done, rx_valid, tx_taken}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table
    for (int vi = 0; vi < NV; vi++) run_xfer(VECS[vi], vi, 1'b0);

    // R10: zero byte count is ignored
    begin
      int seen_busy;
      seen_busy = 0;
      @(negedge clk);
      start = 1'b1; byte_count = '0; cap_mode = 1'b1; div_half = 4'd2;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (busy || !cs_n) seen_busy++;
        @(negedge clk);
      end
      check(seen_busy == 0, "R10", "zero count start ignored", seen_busy, 0);
    end

    // R10: start during a transfer is ignored (would ask for 5 bytes)
    run_xfer('{1'b1, 4'd4, 4'd1, 8'd3, 1'b1}, 10, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule